// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a watchdog that has to be serviced inside a time window. A 7-bit down-counter steps once per prescaled tick. The tick is the bus clock divided by a fixed power of two (4096 by default) and then by 1, 2, 4 or 8. Software starts the watchdog once and then reloads the counter at regular intervals. A reload that comes too late or too early ends in a one-cycle system reset request.

The watchdog counts as too late when the counter steps from 0x40 to 0x3F, which is the moment its bit 6 falls. It counts as too early when the counter is still above a programmed window value at the moment of a reload. One tick before expiry, the counter reaches 0x40 and sets a warning flag. If software has enabled it, that flag drives an interrupt. The enable bit and the interrupt enable bit both stay set until system reset.

Software reaches the block through a single-cycle write port and a combinational read port. The port has three registers. Address 0 is control, address 1 is configuration and address 2 is status.

Top module: `wdt_window`

## Requirements
- R1: After reset, control reads 0x07F (counter 0x7F, inactive). Configuration reads 0x07F (window 0x7F, divider select 0, interrupt off). Status reads 0. Both outputs are low.
- R2: A write to control (address 0) loads data[6:0] into the counter. Data bit 7 = 1 starts the watchdog. Writing 0 to bit 7 never stops it, and control bit 7 reads back the active state.
- R3: While active, the counter decreases by one every 2^(BASE_LOG2+s) bus cycles. Here s is configuration bits [8:7] and the window is configuration bits [6:0]. The first tick after a start or reload comes a full period later.
- R4: When a tick moves the counter from 0x40 to 0x3F, a reset request pulse is issued.
- R5: A control write while active, with the counter strictly above the window, issues a reset request. A counter equal to the window is accepted.
- R6: A control write whose data[6] is 0 issues an immediate reset request if the watchdog is active or is being started by that write.
- R7: A control write while active, with the counter at or below the window and data[6] = 1, issues no reset request. It also restarts the prescaler.
- R8: The tick that brings the counter to 0x40 sets status bit 0. Writing status with bit 0 = 0 clears it. Writing status with bit 0 = 1 leaves it unchanged.
- R9: irq_o is high exactly when status bit 0 and the interrupt enable are both set. The interrupt enable is set by writing configuration bit 9 = 1, and writing 0 to that bit does not clear it.
- R10: rst_req_o is a one-cycle pulse, issued only for the first violation after reset. Later violations give no further pulse.
- R11: While inactive, the counter holds its value, control writes without bit 7 only load it, and no reset request is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous system reset |
| wr_en_i | input | 1 | Register write strobe, one cycle per write |
| addr_i | input | 2 | Register address: 0 control, 1 configuration, 2 status |
| wdata_i | input | 10 | Write data |
| rdata_o | output | 10 | Read data for addr_i, combinational |
| rst_req_o | output | 1 | One-cycle system reset request |
| irq_o | output | 1 | Early-warning interrupt |

## Verification
The bench aims at the cycle exactly before and after each tick after a reload. A prescaler that is not restarted on reload shows up there as a tick one cycle too early.

It places a reload with the counter equal to the window and another one just above it. An off-by-one window comparison either resets a valid service or lets an early one pass.

It writes a nonzero value to status and a zero to the interrupt-enable bit. A flag or enable that is not sticky makes the interrupt drop too soon. The bench also commits a second violation after expiry, so a design that pulses more than once gives an extra reset request.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int CNT_W  = 7;
  localparam int SEL_W  = 2;
  localparam int REG_W  = 10;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CFG  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd2;

  localparam int CTRL_ACT_BIT = 7;
  localparam int CFG_SEL_LSB  = 7;
  localparam int CFG_IE_BIT   = 9;

  localparam logic [CNT_W-1:0] EXPIRE_VAL = 7'h40;
  localparam logic [CNT_W-1:0] WARN_VAL   = 7'h41;
  localparam logic [CNT_W-1:0] CNT_RST    = 7'h7F;

  typedef struct packed {
    logic             ie;
    logic [SEL_W-1:0] sel;
    logic [CNT_W-1:0] win;
  } cfg_t;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int BASE_LOG2 = 12,
  parameter int SEL_W     = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int MAX_SEL = (1 << SEL_W) - 1;
  localparam int PW      = BASE_LOG2 + MAX_SEL;

  logic [PW-1:0] cnt_q;
  logic [PW-1:0] mask;

  // low BASE_LOG2+sel bits all ones marks the last cycle of a period
  assign mask   = {PW{1'b1}} >> (MAX_SEL - int'(sel_i));
  assign tick_o = run_i && !restart_i && ((cnt_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (run_i)     cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/wdt_core.sv
module wdt_core
  import wdt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             start_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] win_i,
  input  logic             flag_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             active_o,
  output logic             flag_o,
  output logic             fired_o,
  output logic             rst_req_o
);
  logic [CNT_W-1:0] cnt_q;
  logic active_q, flag_q, fired_q, req_q;
  logic active_d, early, too_low, expire, violation, step;

  assign active_d  = active_q | (load_i & start_i);
  assign step      = tick_i & active_q;
  assign early     = load_i & active_q & (cnt_q > win_i);
  assign too_low   = load_i & active_d & ~load_val_i[CNT_W-1];
  assign expire    = step & (cnt_q == EXPIRE_VAL);
  assign violation = early | too_low | expire;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= CNT_RST;
      active_q <= 1'b0;
      flag_q   <= 1'b0;
      fired_q  <= 1'b0;
      req_q    <= 1'b0;
    end else begin
      active_q <= active_d;
      req_q    <= violation & ~fired_q;
      fired_q  <= fired_q | violation;
      if (load_i)    cnt_q <= load_val_i;
      else if (step) cnt_q <= cnt_q - 1'b1;
      // set wins over a clear in the same cycle
      if (step && cnt_q == WARN_VAL) flag_q <= 1'b1;
      else if (flag_clr_i)           flag_q <= 1'b0;
    end
  end

  assign cnt_o     = cnt_q;
  assign active_o  = active_q;
  assign flag_o    = flag_q;
  assign fired_o   = fired_q;
  assign rst_req_o = req_q;
endmodule

// File: rtl/wdt_window.sv
module wdt_window
  import wdt_pkg::*;
#(
  parameter int BASE_LOG2 = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              rst_req_o,
  output logic              irq_o
);
  cfg_t cfg_q;
  logic ctrl_wr, cfg_wr, stat_wr;
  logic tick_w, active_w, flag_w, fired_w, restart_w;
  logic [CNT_W-1:0] cnt_w;

  assign ctrl_wr   = wr_en_i && addr_i == ADDR_CTRL;
  assign cfg_wr    = wr_en_i && addr_i == ADDR_CFG;
  assign stat_wr   = wr_en_i && addr_i == ADDR_STAT;
  assign restart_w = ctrl_wr && (active_w || wdata_i[CTRL_ACT_BIT]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '{ie: 1'b0, sel: '0, win: CNT_RST};
    end else if (cfg_wr) begin
      cfg_q.win <= wdata_i[CNT_W-1:0];
      cfg_q.sel <= wdata_i[CFG_SEL_LSB +: SEL_W];
      cfg_q.ie  <= cfg_q.ie | wdata_i[CFG_IE_BIT];
    end
  end

  wdt_prescaler #(.BASE_LOG2(BASE_LOG2), .SEL_W(SEL_W)) u_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (active_w),
    .restart_i (restart_w),
    .sel_i     (cfg_q.sel),
    .tick_o    (tick_w)
  );

  wdt_core u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (ctrl_wr),
    .load_val_i (wdata_i[CNT_W-1:0]),
    .start_i    (wdata_i[CTRL_ACT_BIT]),
    .tick_i     (tick_w),
    .win_i      (cfg_q.win),
    .flag_clr_i (stat_wr && !wdata_i[0]),
    .cnt_o      (cnt_w),
    .active_o   (active_w),
    .flag_o     (flag_w),
    .fired_o    (fired_w),
    .rst_req_o  (rst_req_o)
  );

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_CTRL: rdata_o[CNT_W:0] = {active_w, cnt_w};
      ADDR_CFG:  rdata_o = cfg_q;
      ADDR_STAT: rdata_o[0] = flag_w;
      default:   rdata_o = '0;
    endcase
  end

  assign irq_o = flag_w & cfg_q.ie;
endmodule

// File: rtl/wdt_window_chk.sv
module wdt_window_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ctrl_wr,
  input logic       start_bit,
  input logic       act_q,
  input logic       ie_q,
  input logic [6:0] cnt_q,
  input logic       flag_q,
  input logic       tick,
  input logic       fired,
  input logic       rst_req_o
);
  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o); // R10
  AST_NO_SECOND_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fired |=> !rst_req_o || !$past(fired)); // R10
  AST_ACTIVE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q |=> act_q); // R2
  AST_IE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ie_q |=> ie_q); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!act_q && !ctrl_wr) |=> $stable(cnt_q)); // R11
  AST_IDLE_NO_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!act_q && !(ctrl_wr && start_bit)) |=> !rst_req_o); // R11
  AST_TICK_DECREMENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && tick && !ctrl_wr) |=> cnt_q == $past(cnt_q) - 7'd1); // R3
  AST_EXPIRY_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && tick && !ctrl_wr && cnt_q == 7'h40 && !fired) |=> rst_req_o); // R4
  AST_WARN_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && tick && !ctrl_wr && cnt_q == 7'h41) |=> flag_q); // R8
endmodule

bind wdt_window wdt_window_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ctrl_wr   (ctrl_wr),
  .start_bit (wdata_i[7]),
  .act_q     (active_w),
  .ie_q      (cfg_q.ie),
  .cnt_q     (cnt_w),
  .flag_q    (flag_w),
  .tick      (tick_w),
  .fired     (fired_w),
  .rst_req_o (rst_req_o)
);

// File: tb/wdt_window_bench.sv
`timescale 1ns/1ps
module wdt_window_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [1:0] addr_i = 2'd0;
  logic [9:0] wdata_i = '0;
  logic [9:0] rdata_o;
  logic       rst_req_o, irq_o;

  int n_chk = 0, n_fail = 0, pulse_cnt = 0;
  logic prev_req = 1'b0;
  logic [9:0] exp_q[$];
  string      tag_q[$];
  event       mon_ev;

  always #4 clk_i = ~clk_i;

  wdt_window #(.BASE_LOG2(2)) u_wdt_window (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .rst_req_o(rst_req_o), .irq_o(irq_o)
  );

  // scoreboard monitor: compares read data against queued expectations
  always @(mon_ev) begin
    while (exp_q.size() > 0) begin
      logic [9:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_chk++;
      if (rdata_o !== e) begin
        n_fail++;
        $display("FAIL %s: rdata actual 0x%03h expected 0x%03h", t, rdata_o, e);
      end
    end
  end

  // pulse monitor
  always @(negedge clk_i) begin
    if (rst_req_o === 1'b1) pulse_cnt++;
    if (prev_req && rst_req_o === 1'b1) begin
      n_chk++; n_fail++;
      $display("FAIL R10: rst_req_o actual 1 expected 0 (pulse longer than one cycle)");
    end
    prev_req = (rst_req_o === 1'b1);
  end

  task automatic rd(input logic [1:0] a, input logic [9:0] e, input string t);
    addr_i = a;
    #0.1;
    exp_q.push_back(e);
    tag_q.push_back(t);
    -> mon_ev;
    #0.1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [9:0] d);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic chk(input string t, input int act, input int e);
    n_chk++;
    if (act != e) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", t, act, e);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; wr_en_i = 1'b0;
    cyc(3);
    rst_ni = 1'b1;
    pulse_cnt = 0;
    cyc(1);
  endtask

  initial begin
    #(8.0 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    cyc(1);
    do_reset();
    // R1 reset state
    rd(2'd0, 10'h07F, "R1 ctrl");
    rd(2'd1, 10'h07F, "R1 cfg");
    rd(2'd2, 10'h000, "R1 status");
    chk("R1 rst_req_o", int'(rst_req_o), 0);
    chk("R1 irq_o", int'(irq_o), 0);
    // R11 idle
    cyc(40);
    rd(2'd0, 10'h07F, "R11 idle hold");
    wr(2'd0, 10'h045);
    rd(2'd0, 10'h045, "R2 load inactive");
    wr(2'd0, 10'h030);
    rd(2'd0, 10'h030, "R11 low load inactive");
    chk("R11 no pulse while idle", pulse_cnt, 0);
    wr(2'd1, 10'h260);
    rd(2'd1, 10'h260, "R3 cfg write");
    // start at E0, sel 0: period 4
    wr(2'd0, 10'h0D0);
    rd(2'd0, 10'h0D0, "R2 start");
    cyc(3); rd(2'd0, 10'h0D0, "R3 before first tick");
    cyc(1); rd(2'd0, 10'h0CF, "R3 first tick");
    cyc(4); rd(2'd0, 10'h0CE, "R3 second tick");
    // in-window reload at E9 with bit7=0
    wr(2'd0, 10'h058);
    rd(2'd0, 10'h0D8, "R2 stays active");
    chk("R7 no pulse in window", pulse_cnt, 0);
    cyc(3); rd(2'd0, 10'h0D8, "R7 prescaler restarted");
    cyc(1); rd(2'd0, 10'h0D7, "R7 tick full period after reload");
    // sel 1: period 8
    wr(2'd1, 10'h2E0);
    wr(2'd0, 10'h050);
    rd(2'd0, 10'h0D0, "R3 reload sel1");
    cyc(7); rd(2'd0, 10'h0D0, "R3 sel1 before tick");
    cyc(1); rd(2'd0, 10'h0CF, "R3 sel1 tick");
    cyc(119);
    rd(2'd2, 10'h000, "R8 flag not yet");
    chk("R9 irq low before warning", int'(irq_o), 0);
    cyc(1);
    rd(2'd0, 10'h0C0, "R8 counter at 0x40");
    rd(2'd2, 10'h001, "R8 flag set");
    chk("R9 irq high", int'(irq_o), 1);
    wr(2'd2, 10'h001);
    rd(2'd2, 10'h001, "R8 write 1 keeps flag");
    wr(2'd1, 10'h0E0);
    rd(2'd1, 10'h2E0, "R9 enable sticky");
    chk("R9 irq still high", int'(irq_o), 1);
    wr(2'd2, 10'h000);
    rd(2'd2, 10'h000, "R8 clear");
    chk("R9 irq low after clear", int'(irq_o), 0);
    cyc(4);
    chk("R4 no pulse before expiry", pulse_cnt, 0);
    cyc(1);
    chk("R4 expiry pulse", int'(rst_req_o), 1);
    rd(2'd0, 10'h0BF, "R4 counter 0x3F");
    cyc(1);
    chk("R10 pulse one cycle", int'(rst_req_o), 0);
    wr(2'd0, 10'h010);
    cyc(2);
    chk("R10 only first violation", pulse_cnt, 1);
    rd(2'd0, 10'h090, "R10 load after fire");

    // R5 early reload
    do_reset();
    wr(2'd1, 10'h050);
    wr(2'd0, 10'h0FF);
    chk("R5 start no pulse", int'(rst_req_o), 0);
    wr(2'd0, 10'h07F);
    chk("R5 early reload pulse", int'(rst_req_o), 1);
    cyc(1);
    chk("R5 single pulse", pulse_cnt, 1);

    // R6 start with low value
    do_reset();
    wr(2'd0, 10'h0BF);
    chk("R6 start low pulse", int'(rst_req_o), 1);
    rd(2'd0, 10'h0BF, "R6 loaded");

    // R6 low reload while active
    do_reset();
    wr(2'd0, 10'h0C5);
    chk("R6 valid start", int'(rst_req_o), 0);
    wr(2'd0, 10'h020);
    chk("R6 low reload pulse", int'(rst_req_o), 1);

    // R5 boundary: counter equal to window
    do_reset();
    wr(2'd1, 10'h04A);
    wr(2'd0, 10'h0CA);
    wr(2'd0, 10'h04A);
    cyc(1);
    chk("R5 equal to window accepted", pulse_cnt, 0);
    rd(2'd0, 10'h0CA, "R7 reload value");

    // R5 boundary: one above window
    do_reset();
    wr(2'd1, 10'h049);
    wr(2'd0, 10'h0CA);
    wr(2'd0, 10'h04A);
    chk("R5 one above window", int'(rst_req_o), 1);

    cyc(2);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule